// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from a set of external pins and internal peripheral lines, picks the single most urgent one, and hands its vector fetch address to a CPU through a small strobe-and-done handshake. Each vector occupies a 4-byte slot in a table. The table's base address is zero after reset and can be relocated at any time. Vector numbers are assigned as follows: 0 for reset, then the external pins in index order, then the internal lines in index order. A lower number always wins.

A global enable flag gates every maskable request. Accepting an interrupt clears the flag automatically. A return-from-interrupt pulse sets it again, and separate set and clear commands force it. If a handler sets the flag while it runs, a nested interrupt can be taken. External pins also need their own enable bit. Each pin has its own trigger selection: low level, falling edge, rising edge, or off. Every pin passes through a two-flop synchronizer first. Edge events are latched as pending flags, while level requests follow the pin.

Top module: `vic_top`

## Requirements
- R1: When several requests are eligible in the same cycle, the one with the lowest vector number is accepted. Vector 0 is reset, vectors 1..N_EXT are external pins 0..N_EXT-1, and the internal lines follow in index order.
- R2: The vector address equals the table base plus 4 times the vector number. The base is 0 after reset and is loaded from `base_i` in the cycle after `base_wr_i` is high.
- R3: `gie_o` is 0 after reset. It becomes 1 one cycle after `gie_set_i` or `reti_i`, and 0 one cycle after `gie_clr_i`. A clear wins over a set in the same cycle. A set issued inside a handler allows a further interrupt before any return.
- R4: A maskable request (every vector except 0) is accepted only while `gie_o` is 1. Accepting any vector clears `gie_o`, even if a set command arrives in the same cycle.
- R5: An external pin's request is accepted only while its `ext_en_i` bit is 1. Internal lines need only the global enable.
- R6: An acceptance raises `irq_valid_o` for exactly one cycle. `irq_num_o` and `irq_addr_o` then hold until the next acceptance. No further acceptance happens until `cpu_done_i` has been sampled high.
- R7: After reset is released, vector 0 is accepted at the first clock edge, whatever the state of `gie_o`.
- R8: The per-pin mode in `ext_mode_i[2p+1:2p]` works as follows. 00 requests while the synchronized pin is low and latches nothing. 01 latches a pending flag on a falling edge. 10 latches a pending flag on a rising edge. 11 never requests. A pending flag is set even while the pin is disabled, and it clears when its own vector is accepted.
- R9: Latency counts the clock edges after the edge that first samples an input change, with that edge as edge 1. An internal line is accepted at edge 1, a low-level pin at edge 3 and a pin edge at edge 4. `irq_valid_o` is visible in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_i | input | N_EXT | Asynchronous external request pins |
| ext_en_i | input | N_EXT | Per-pin enable |
| ext_mode_i | input | 2*N_EXT | Per-pin trigger mode, two bits per pin |
| int_req_i | input | N_INT | Internal request lines, held by the source until served |
| gie_set_i | input | 1 | Force global enable to 1 |
| gie_clr_i | input | 1 | Force global enable to 0 |
| reti_i | input | 1 | Return from interrupt, sets global enable |
| base_wr_i | input | 1 | Load a new table base |
| base_i | input | ADDR_W | New table base value |
| cpu_done_i | input | 1 | CPU has finished taking the current vector |
| irq_valid_o | output | 1 | One-cycle strobe for a newly accepted vector |
| irq_num_o | output | VEC_W | Accepted vector number |
| irq_addr_o | output | ADDR_W | Vector fetch address |
| gie_o | output | 1 | Current global enable |

## Verification
An internal line driven before a clock edge is accepted at that edge. A low pin is accepted at the third edge, and a pin edge at the fourth, counting the edge that first samples the pin. The strobe, vector number and address appear one cycle after the accepting edge. The global enable changes on the edge after a command. The bench keeps a behavioural reference model that advances on every rising edge from the same inputs. It compares strobe, number, address and enable on the following falling edge, so each result is checked in exactly the cycle it is due. Directed sequences wait for the strobe inside a bounded window. They then confirm the vector, the one-cycle width of the strobe and the cleared enable. Stretches where nothing may be accepted are watched cycle by cycle.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;

  // Trigger selection per external pin
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_OFF  = 2'b11
  } trig_mode_e;

  // CPU-side handshake state
  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_WAIT = 1'b1
  } hs_state_e;

  // log2 of the vector slot size in bytes
  localparam int SLOT_SHIFT = 2;

endpackage

// File: rtl/vic_ext_trigger.sv
`timescale 1ns/1ps
module vic_ext_trigger
  import vic_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_i,
  input  logic [1:0] mode_i,
  input  logic       ack_i,
  output logic       req_o
);

  logic       meta_q, sync_q, hist_q;
  logic       pend_q;
  logic       evt;
  trig_mode_e mode;

  assign mode = trig_mode_e'(mode_i);

  // Two-flop synchronizer plus one history flop for edge detection.
  // Reset to high so an idle (high) pin produces no spurious edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      hist_q <= 1'b1;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  always_comb begin
    case (mode)
      TRIG_RISE: evt = sync_q & ~hist_q;
      TRIG_FALL: evt = ~sync_q & hist_q;
      default:   evt = 1'b0;
    endcase
  end

  // Edge pending flag: a new event beats a simultaneous acknowledge
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (mode == TRIG_LOW || mode == TRIG_OFF) begin
      pend_q <= 1'b0;
    end else if (evt) begin
      pend_q <= 1'b1;
    end else if (ack_i) begin
      pend_q <= 1'b0;
    end
  end

  always_comb begin
    case (mode)
      TRIG_LOW:  req_o = ~sync_q;
      TRIG_FALL,
      TRIG_RISE: req_o = pend_q;
      default:   req_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/vic_prio_arb.sv
`timescale 1ns/1ps
module vic_prio_arb #(
  parameter int N     = 7,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  // Scan from the top down so the lowest set index is the last written
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/vic_top.sv
`timescale 1ns/1ps
module vic_top
  import vic_pkg::*;
#(
  parameter int N_EXT  = 2,
  parameter int N_INT  = 4,
  parameter int ADDR_W = 16,
  parameter int VEC_W  = $clog2(1 + N_EXT + N_INT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_EXT-1:0]     ext_pin_i,
  input  logic [N_EXT-1:0]     ext_en_i,
  input  logic [2*N_EXT-1:0]   ext_mode_i,
  input  logic [N_INT-1:0]     int_req_i,
  input  logic                 gie_set_i,
  input  logic                 gie_clr_i,
  input  logic                 reti_i,
  input  logic                 base_wr_i,
  input  logic [ADDR_W-1:0]    base_i,
  input  logic                 cpu_done_i,
  output logic                 irq_valid_o,
  output logic [VEC_W-1:0]     irq_num_o,
  output logic [ADDR_W-1:0]    irq_addr_o,
  output logic                 gie_o
);

  localparam int NVEC     = 1 + N_EXT + N_INT;
  localparam int EXT_BASE = 1;
  localparam int INT_BASE = 1 + N_EXT;

  logic [NVEC-1:0]   req_vec;
  logic [N_EXT-1:0]  ext_req;
  logic [N_EXT-1:0]  ext_ack;
  logic              win_any;
  logic [VEC_W-1:0]  win_idx;
  logic              accept;
  logic              rst_pend_q;
  logic              gie_q;
  logic [ADDR_W-1:0] base_q;
  hs_state_e         hs_q;

  // External pin conditioning, one instance per pin
  for (genvar p = 0; p < N_EXT; p++) begin : g_ext
    vic_ext_trigger u_trig (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (ext_pin_i[p]),
      .mode_i (ext_mode_i[2*p +: 2]),
      .ack_i  (ext_ack[p]),
      .req_o  (ext_req[p])
    );
    assign ext_ack[p]            = accept && (win_idx == VEC_W'(EXT_BASE + p));
    assign req_vec[EXT_BASE + p] = gie_q & ext_en_i[p] & ext_req[p];
  end

  for (genvar q = 0; q < N_INT; q++) begin : g_int
    assign req_vec[INT_BASE + q] = gie_q & int_req_i[q];
  end

  assign req_vec[0] = rst_pend_q;

  vic_prio_arb #(
    .N     (NVEC),
    .IDX_W (VEC_W)
  ) u_arb (
    .req_i (req_vec),
    .any_o (win_any),
    .idx_o (win_idx)
  );

  assign accept = (hs_q == HS_IDLE) && win_any;

  // Handshake, vector outputs and reset vector
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q        <= HS_IDLE;
      rst_pend_q  <= 1'b1;
      irq_valid_o <= 1'b0;
      irq_num_o   <= '0;
      irq_addr_o  <= '0;
    end else if (accept) begin
      hs_q        <= HS_WAIT;
      irq_valid_o <= 1'b1;
      irq_num_o   <= win_idx;
      irq_addr_o  <= base_q + (ADDR_W'(win_idx) << SLOT_SHIFT);
      if (win_idx == '0) rst_pend_q <= 1'b0;
    end else begin
      irq_valid_o <= 1'b0;
      if (hs_q == HS_WAIT && cpu_done_i) hs_q <= HS_IDLE;
    end
  end

  // Global enable: acceptance clears, then clear command, then set
  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q <= 1'b0;
    end else if (accept || gie_clr_i) begin
      gie_q <= 1'b0;
    end else if (gie_set_i || reti_i) begin
      gie_q <= 1'b1;
    end
  end

  // Relocatable vector table base
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else if (base_wr_i) begin
      base_q <= base_i;
    end
  end

  assign gie_o = gie_q;

endmodule

// File: rtl/vic_checker.sv
`timescale 1ns/1ps
module vic_checker #(
  parameter int N_EXT  = 2,
  parameter int N_INT  = 4,
  parameter int ADDR_W = 16,
  parameter int VEC_W  = $clog2(1 + N_EXT + N_INT)
) (
  input logic              clk,
  input logic              rst,
  input logic [N_EXT-1:0]  ext_en_i,
  input logic              gie_set_i,
  input logic              gie_clr_i,
  input logic              reti_i,
  input logic              base_wr_i,
  input logic [ADDR_W-1:0] base_i,
  input logic              cpu_done_i,
  input logic              irq_valid_o,
  input logic [VEC_W-1:0]  irq_num_o,
  input logic [ADDR_W-1:0] irq_addr_o,
  input logic              gie_o
);

  logic [ADDR_W-1:0] base_seen;
  logic [N_EXT-1:0]  en_q;
  logic              busy_q;
  logic              en_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_seen <= '0;
      en_q      <= '0;
      busy_q    <= 1'b0;
    end else begin
      if (base_wr_i) base_seen <= base_i;
      en_q <= ext_en_i;
      if (cpu_done_i)       busy_q <= 1'b0;
      else if (irq_valid_o) busy_q <= 1'b1;
    end
  end

  always_comb begin
    en_ok = 1'b1;
    for (int i = 0; i < N_EXT; i++) begin
      if (irq_num_o == VEC_W'(i + 1)) en_ok = en_q[i];
    end
  end

  p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |=> !irq_valid_o);

  p_hold_vector_r6: assert property (@(posedge clk) disable iff (rst)
    !irq_valid_o |-> ($stable(irq_num_o) && $stable(irq_addr_o)));

  p_wait_done_r6: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> !busy_q);

  p_accept_clears_gie_r4: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> !gie_o);

  p_masked_needs_gie_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_valid_o && irq_num_o != '0) |-> $past(gie_o));

  p_ext_enable_r5: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> en_ok);

  p_vector_addr_r2: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> (irq_addr_o == $past(base_seen) + (ADDR_W'(irq_num_o) << 2)));

  p_clear_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(gie_clr_i)) |-> !gie_o);

  p_set_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(gie_set_i || reti_i) && !$past(gie_clr_i) && !irq_valid_o) |-> gie_o);

  p_reset_vector_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !rst) |=> (irq_valid_o && irq_num_o == '0));

endmodule

bind vic_top vic_checker #(
  .N_EXT  (N_EXT),
  .N_INT  (N_INT),
  .ADDR_W (ADDR_W),
  .VEC_W  (VEC_W)
) u_vic_checker (
  .clk         (clk),
  .rst         (rst),
  .ext_en_i    (ext_en_i),
  .gie_set_i   (gie_set_i),
  .gie_clr_i   (gie_clr_i),
  .reti_i      (reti_i),
  .base_wr_i   (base_wr_i),
  .base_i      (base_i),
  .cpu_done_i  (cpu_done_i),
  .irq_valid_o (irq_valid_o),
  .irq_num_o   (irq_num_o),
  .irq_addr_o  (irq_addr_o),
  .gie_o       (gie_o)
);

// File: tb/test_vic_top.sv
`timescale 1ns/1ps
module test_vic_top;

  localparam int N_EXT  = 2;
  localparam int N_INT  = 4;
  localparam int ADDR_W = 16;
  localparam int NVEC   = 1 + N_EXT + N_INT;
  localparam int VEC_W  = $clog2(NVEC);

  logic                clk = 1'b0;
  logic                rst;
  logic [N_EXT-1:0]    ext_pin;
  logic [N_EXT-1:0]    ext_en;
  logic [2*N_EXT-1:0]  ext_mode;
  logic [N_INT-1:0]    int_req;
  logic                gie_set, gie_clr, reti, base_wr, cpu_done;
  logic [ADDR_W-1:0]   base_in;
  logic                irq_valid;
  logic [VEC_W-1:0]    irq_num;
  logic [ADDR_W-1:0]   irq_addr;
  logic                gie;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  vic_top #(.N_EXT(N_EXT), .N_INT(N_INT), .ADDR_W(ADDR_W), .VEC_W(VEC_W)) i_vic_top (
    .clk(clk), .rst(rst), .ext_pin_i(ext_pin), .ext_en_i(ext_en), .ext_mode_i(ext_mode),
    .int_req_i(int_req), .gie_set_i(gie_set), .gie_clr_i(gie_clr), .reti_i(reti),
    .base_wr_i(base_wr), .base_i(base_in), .cpu_done_i(cpu_done),
    .irq_valid_o(irq_valid), .irq_num_o(irq_num), .irq_addr_o(irq_addr), .gie_o(gie)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_seen1[N_EXT], m_seen2[N_EXT], m_seen3[N_EXT], m_pend[N_EXT];
  bit m_rvec, m_busy, m_gie, m_valid;
  int m_num, m_addr, m_base;
  bit m_started = 0;

  always @(posedge clk) begin
    bit want[NVEC];
    int win;
    bit acc;
    int md;
    if (rst) begin
      for (int p = 0; p < N_EXT; p++) begin
        m_seen1[p] = 1; m_seen2[p] = 1; m_seen3[p] = 1; m_pend[p] = 0;
      end
      m_rvec = 1; m_busy = 0; m_gie = 0; m_valid = 0;
      m_num = 0; m_addr = 0; m_base = 0;
    end else begin
      want[0] = m_rvec;
      for (int p = 0; p < N_EXT; p++) begin
        md = int'(ext_mode[2*p +: 2]);
        want[1+p] = m_gie && ext_en[p] &&
                    ((md == 0 && !m_seen2[p]) || ((md == 1 || md == 2) && m_pend[p]));
      end
      for (int q = 0; q < N_INT; q++) want[1+N_EXT+q] = m_gie && int_req[q];
      win = -1;
      for (int i = 0; i < NVEC; i++) if (want[i] && win < 0) win = i;
      acc = !m_busy && (win >= 0);
      for (int p = 0; p < N_EXT; p++) begin
        bit ev;
        md = int'(ext_mode[2*p +: 2]);
        ev = (md == 2 && m_seen2[p] && !m_seen3[p]) || (md == 1 && !m_seen2[p] && m_seen3[p]);
        if (md == 0 || md == 3) m_pend[p] = 0;
        else if (ev) m_pend[p] = 1;
        else if (acc && win == 1 + p) m_pend[p] = 0;
        m_seen3[p] = m_seen2[p]; m_seen2[p] = m_seen1[p]; m_seen1[p] = ext_pin[p];
      end
      if (acc) begin
        m_valid = 1; m_num = win; m_addr = (m_base + 4 * win) & 'hFFFF; m_busy = 1;
        if (win == 0) m_rvec = 0;
      end else begin
        m_valid = 0;
        if (m_busy && cpu_done) m_busy = 0;
      end
      if (acc || gie_clr) m_gie = 0;
      else if (gie_set || reti) m_gie = 1;
      if (base_wr) m_base = int'(base_in);
    end
    m_started = 1;
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (m_started && !done) begin
      chk(irq_valid == m_valid, "R6 model strobe", int'(irq_valid), int'(m_valid));
      chk(int'(irq_num) == m_num, "R1 model vector number", int'(irq_num), m_num);
      chk(int'(irq_addr) == m_addr, "R2 model vector address", int'(irq_addr), m_addr);
      chk(gie == m_gie, "R3 model global enable", int'(gie), int'(m_gie));
    end
  end

  // ---------------- directed helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_set();  gie_set = 1; cyc(1); gie_set = 0; endtask
  task automatic pulse_clr();  gie_clr = 1; cyc(1); gie_clr = 0; endtask
  task automatic pulse_reti(); reti = 1;    cyc(1); reti = 0;    endtask

  task automatic expect_vec(input int num, input int addr, input string tag);
    bit found = 0;
    for (int i = 0; i < 30 && !found; i++) begin
      @(negedge clk);
      if (irq_valid) found = 1;
    end
    chk(found, {tag, " strobe seen"}, int'(found), 1);
    chk(int'(irq_num) == num, {tag, " vector number"}, int'(irq_num), num);
    chk(int'(irq_addr) == addr, {tag, " vector address"}, int'(irq_addr), addr);
    @(negedge clk);
    chk(!irq_valid, "R6 strobe one cycle", int'(irq_valid), 0);
    chk(!gie, "R4 accept clears enable", int'(gie), 0);
    cpu_done = 1; cyc(1); cpu_done = 0;
  endtask

  task automatic expect_none(input int n, input string tag);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_valid) hits++;
    end
    chk(hits == 0, {tag, " no acceptance"}, hits, 0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    rst = 1; ext_pin = '1; ext_en = '0; ext_mode = '0; int_req = '0;
    gie_set = 0; gie_clr = 0; reti = 0; base_wr = 0; base_in = '0; cpu_done = 0;
    cyc(4);
    chk(!irq_valid, "R6 reset strobe low", int'(irq_valid), 0);
    chk(!gie, "R3 reset enable low", int'(gie), 0);
    rst = 0;
    expect_vec(0, 0, "R7 reset vector");

    // masked internal request, then enabled (R4)
    int_req = 4'b0001;
    expect_none(6, "R4 masked");
    pulse_set();
    expect_vec(3, 12, "R4 internal after set");
    int_req = '0;
    pulse_reti();
    chk(gie, "R3 reti sets enable", int'(gie), 1);

    // simultaneous internal requests (R1)
    int_req = 4'b1010;
    expect_vec(4, 16, "R1 lower number wins");
    int_req = 4'b1000;
    pulse_reti();
    expect_vec(6, 24, "R1 remaining request");
    int_req = '0;
    pulse_reti();

    // enable commands (R3)
    pulse_clr();
    chk(!gie, "R3 clear command", int'(gie), 0);
    gie_set = 1; gie_clr = 1; cyc(1); gie_set = 0; gie_clr = 0;
    chk(!gie, "R3 clear wins over set", int'(gie), 0);
    pulse_set();

    // pin 0 rising edge while disabled (R5, R8)
    ext_mode = 4'b0010;
    ext_pin[0] = 0; cyc(5);
    ext_pin[0] = 1;
    expect_none(8, "R5 disabled pin");
    ext_en = 2'b01;
    expect_vec(1, 4, "R5 pending taken once enabled");
    pulse_reti();
    expect_none(8, "R8 pending cleared by accept");

    // pin 1 falling edge (R8, R9)
    ext_mode = 4'b0110; ext_en = 2'b11;
    ext_pin[1] = 0;
    expect_vec(2, 8, "R8 falling edge");
    pulse_reti();
    expect_none(8, "R8 edge not repeated while low");
    ext_pin[1] = 1; cyc(4);

    // pin 1 low level (R8)
    ext_mode = 4'b0010;
    ext_pin[1] = 0;
    expect_vec(2, 8, "R8 low level");
    pulse_reti();
    expect_vec(2, 8, "R8 level not latched, still low");
    ext_pin[1] = 1; cyc(4);
    pulse_reti();
    expect_none(8, "R8 level released");

    // pin 0 off mode (R8)
    ext_mode = 4'b0011;
    ext_pin[0] = 0; cyc(4); ext_pin[0] = 1;
    expect_none(8, "R8 off mode");

    // relocated table (R2)
    base_in = 16'h0100; base_wr = 1; cyc(1); base_wr = 0;
    int_req = 4'b0100;
    expect_vec(5, 'h114, "R2 relocated base");
    int_req = '0;
    pulse_reti();

    // handshake hold and nesting (R6, R3)
    begin
      bit found = 0;
      int_req = 4'b0001;
      for (int i = 0; i < 10 && !found; i++) begin
        @(negedge clk);
        if (irq_valid) found = 1;
      end
      chk(found, "R6 strobe seen", int'(found), 1);
      pulse_set();
      expect_none(6, "R6 held until done");
      chk(int'(irq_num) == 3, "R6 vector held", int'(irq_num), 3);
      cpu_done = 1; cyc(1); cpu_done = 0;
      expect_vec(3, 'h10C, "R3 nested after set in handler");
      int_req = '0;
      pulse_reti();
    end

    // second reset (R7, R2)
    rst = 1; cyc(3); rst = 0;
    expect_vec(0, 0, "R7 reset vector again");
    chk(!gie, "R3 enable after reset", int'(gie), 0);

    cyc(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule